// File: doc/BRIEF.md
# Protected Command Sequence Decoder

This block sits between a parallel memory bus and the controller of a two-or-more-bank nonvolatile array. It watches write bus cycles and turns only complete, correctly ordered unlock sequences into commands. A write cycle is one interval during which chip-enable and write-enable are both low and output-enable is high. Each cycle carries an address and a data word. Only the low data byte is decoded as a command code.

A program command needs two unlock cycles, a program code, and then the cycle that gives the target address and data. An erase command needs six cycles in total. Shorter sequences enter an identification mode or an erase-verify mode, and a common exit sequence leaves both. The first accepted cycle reserves a bank, and every later cycle of that sequence must address the same bank. Any wrong cycle sends the decoder back to read mode. While the array controller reports an operation in progress, every write cycle is ignored. The outputs are a one-clock command pulse with the operation type, the target address and the data, plus the mode flags and the reserved bank.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: The sequence AAh at low address 5555h, 55h at 2AAAh, A0h at 5555h, followed by any cycle in the same bank, produces one `cmd_valid` pulse with `cmd_op` = 0 (program), `cmd_addr` equal to the address of the last cycle, and `cmd_data` equal to all 16 bits of its data.
- R2: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by a final cycle, produces a pulse. The final cycle 10h@5555h gives `cmd_op` = 1 (chip erase). A final 50h at any address of the bank gives `cmd_op` = 2 (block erase). A final 30h at any address of the bank gives `cmd_op` = 3 (sector erase). `cmd_addr` is the address of the final cycle. "Low address" means `addr[14:0]`.
- R3: Data bits 15:8 have no effect on any command cycle.
- R4: The address is taken at the first clock sample where both strobes are low. The data is taken at the last such sample before either strobe rises. Either strobe may be the later to fall or the earlier to rise.
- R5: A cycle with a wrong address or code returns the decoder to read mode. The cycles that would have followed then produce no command.
- R6: While `busy` is high, write cycles change no output and no sequence state. A sequence that was interrupted continues after `busy` falls.
- R7: Read accesses (write-enable high) between cycles do not disturb a sequence. A cycle made while output-enable is low is not a write cycle.
- R8: Unlock plus 90h@5555h sets `id_mode`. While `id_mode` is set, no program or erase command is accepted. Unlock plus F0h@5555h clears `id_mode` and `verify_mode`.
- R9: Unlock plus 60h@5555h sets `verify_mode`. Erase commands are still accepted while it is set.
- R10: A strobe-low interval shorter than `MIN_LOW` clock samples is not a cycle. An interval of exactly `MIN_LOW` samples is a cycle.
- R11: `seq_active` is high while a sequence is partly loaded. `seq_bank` (`addr[19:18]`) holds the bank of the first cycle for the whole sequence. A cycle that addresses another bank aborts the sequence.
- R12: After reset, `cmd_valid`, `id_mode`, `verify_mode` and `seq_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low (low inhibits writes) |
| busy | input | 1 | Array operation in progress |
| addr | input | 20 | Bus address; bits 19:18 select the bank |
| data | input | 16 | Bus write data |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_op | output | 2 | 0 program, 1 chip, 2 block, 3 sector erase |
| cmd_addr | output | 20 | Target address of the command |
| cmd_data | output | 16 | Data word of the final cycle |
| id_mode | output | 1 | Identification mode active |
| verify_mode | output | 1 | Erase-verify mode active |
| seq_active | output | 1 | A sequence is partly loaded |
| seq_bank | output | 2 | Bank reserved by the current sequence |

## Verification
Some properties hold on every cycle, and the assertions cover those. The command pulse never lasts longer than one clock. A cycle made while busy changes no flag and issues nothing. No command is issued while identification mode is set. A chip erase always targets the unlock address. The reserved bank stays fixed while a sequence is loading. Other behaviour can only be shown by the bench scenarios checked against a reference sequence model: correct decoding of each operation, aborts on wrong codes or banks, skewed strobe edges, the glitch threshold, and the resumption of a sequence after a busy period.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_CHIP   = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_SECTOR = 2'd3
  } sdp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } sdp_st_e;
endpackage

// File: rtl/sdp_bus_capture.sv
module sdp_bus_capture #(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cyc_stb,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);
  localparam int CW = $clog2(MIN_LOW + 1) + 1;

  logic          act_q, act_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      act_d    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      low_cnt  <= '0;
      cyc_stb  <= 1'b0;
      cyc_addr <= '0;
      cyc_data <= '0;
    end else begin
      act_q   <= !ce_n && !we_n && oe_n;
      addr_q  <= addr;
      data_q  <= data;
      act_d   <= act_q;
      cyc_stb <= 1'b0;
      if (act_q && !act_d) begin
        // later of the two strobes has fallen: take the address
        cyc_addr <= addr_q;
        cyc_data <= data_q;
        low_cnt  <= CW'(1);
      end else if (act_q) begin
        // data follows the bus until the earlier strobe rises
        cyc_data <= data_q;
        if (low_cnt != {CW{1'b1}}) low_cnt <= low_cnt + CW'(1);
      end else if (act_d) begin
        cyc_stb <= (low_cnt >= CW'(MIN_LOW));
      end
    end
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
#(
  parameter int                AW      = 20,
  parameter int                DW      = 16,
  parameter int                BANK_W  = 2,
  parameter int                CMP_W   = 15,
  parameter logic [CMP_W-1:0]  ADDR_A  = 15'h5555,
  parameter logic [CMP_W-1:0]  ADDR_B  = 15'h2AAA,
  parameter logic [7:0]        C_UNL1  = 8'hAA,
  parameter logic [7:0]        C_UNL2  = 8'h55,
  parameter logic [7:0]        C_PGM   = 8'hA0,
  parameter logic [7:0]        C_ERS   = 8'h80,
  parameter logic [7:0]        C_CHIP  = 8'h10,
  parameter logic [7:0]        C_BLK   = 8'h50,
  parameter logic [7:0]        C_SEC   = 8'h30,
  parameter logic [7:0]        C_ID    = 8'h90,
  parameter logic [7:0]        C_VFY   = 8'h60,
  parameter logic [7:0]        C_EXIT  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              cyc_stb,
  input  logic [AW-1:0]     cyc_addr,
  input  logic [DW-1:0]     cyc_data,
  output logic              cmd_valid,
  output sdp_op_e           cmd_op,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_data,
  output logic              id_mode,
  output logic              verify_mode,
  output logic              seq_active,
  output logic [BANK_W-1:0] seq_bank
);
  sdp_st_e           st, nxt;
  logic [BANK_W-1:0] bank_r, bank_n;
  logic              id_n, vf_n, go;
  sdp_op_e           op_n;

  logic [CMP_W-1:0]  lo;
  logic [7:0]        code;
  logic [BANK_W-1:0] bnk;
  logic              same, at_a, at_b;

  assign lo   = cyc_addr[CMP_W-1:0];
  assign code = cyc_data[7:0];
  assign bnk  = cyc_addr[AW-1 -: BANK_W];
  assign same = (bnk == bank_r);
  assign at_a = (lo == ADDR_A);
  assign at_b = (lo == ADDR_B);

  always_comb begin
    nxt    = st;
    bank_n = bank_r;
    id_n   = id_mode;
    vf_n   = verify_mode;
    go     = 1'b0;
    op_n   = OP_PROG;
    if (cyc_stb && !busy) begin
      nxt = ST_IDLE;
      unique case (st)
        ST_IDLE: if (at_a && code == C_UNL1) begin
          nxt    = ST_UNL1;
          bank_n = bnk;
        end
        ST_UNL1: if (same && at_b && code == C_UNL2) nxt = ST_UNL2;
        ST_UNL2: if (same && at_a) begin
          if (code == C_EXIT) begin
            id_n = 1'b0;
            vf_n = 1'b0;
          end else if (!id_mode) begin
            if (code == C_PGM)      nxt  = ST_PGM;
            else if (code == C_ERS) nxt  = ST_ERS1;
            else if (code == C_ID)  id_n = 1'b1;
            else if (code == C_VFY) vf_n = 1'b1;
          end
        end
        ST_PGM: if (same) begin
          go   = 1'b1;
          op_n = OP_PROG;
        end
        ST_ERS1: if (same && at_a && code == C_UNL1) nxt = ST_ERS2;
        ST_ERS2: if (same && at_b && code == C_UNL2) nxt = ST_ERS3;
        ST_ERS3: if (same) begin
          if (at_a && code == C_CHIP) begin
            go = 1'b1; op_n = OP_CHIP;
          end else if (code == C_BLK) begin
            go = 1'b1; op_n = OP_BLOCK;
          end else if (code == C_SEC) begin
            go = 1'b1; op_n = OP_SECTOR;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bank_r      <= '0;
      id_mode     <= 1'b0;
      verify_mode <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_op      <= OP_PROG;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      seq_active  <= 1'b0;
      seq_bank    <= '0;
    end else begin
      st          <= nxt;
      bank_r      <= bank_n;
      id_mode     <= id_n;
      verify_mode <= vf_n;
      cmd_valid   <= go;
      seq_active  <= (nxt != ST_IDLE);
      seq_bank    <= bank_n;
      if (go) begin
        cmd_op   <= op_n;
        cmd_addr <= cyc_addr;
        cmd_data <= cyc_data;
      end
    end
  end
endmodule

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder #(
  parameter int               AW      = 20,
  parameter int               DW      = 16,
  parameter int               BANK_W  = 2,
  parameter int               CMP_W   = 15,
  parameter int               MIN_LOW = 3,
  parameter logic [CMP_W-1:0] ADDR_A  = 15'h5555,
  parameter logic [CMP_W-1:0] ADDR_B  = 15'h2AAA,
  parameter logic [7:0]       C_UNL1  = 8'hAA,
  parameter logic [7:0]       C_UNL2  = 8'h55,
  parameter logic [7:0]       C_PGM   = 8'hA0,
  parameter logic [7:0]       C_ERS   = 8'h80,
  parameter logic [7:0]       C_CHIP  = 8'h10,
  parameter logic [7:0]       C_BLK   = 8'h50,
  parameter logic [7:0]       C_SEC   = 8'h30,
  parameter logic [7:0]       C_ID    = 8'h90,
  parameter logic [7:0]       C_VFY   = 8'h60,
  parameter logic [7:0]       C_EXIT  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_data,
  output logic              id_mode,
  output logic              verify_mode,
  output logic              seq_active,
  output logic [BANK_W-1:0] seq_bank
);
  import sdp_pkg::*;

  logic          cyc_stb;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  sdp_op_e       op_e;

  sdp_bus_capture #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data),
    .cyc_stb(cyc_stb), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  sdp_seq_fsm #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .CMP_W(CMP_W),
    .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
    .C_UNL1(C_UNL1), .C_UNL2(C_UNL2), .C_PGM(C_PGM), .C_ERS(C_ERS),
    .C_CHIP(C_CHIP), .C_BLK(C_BLK), .C_SEC(C_SEC),
    .C_ID(C_ID), .C_VFY(C_VFY), .C_EXIT(C_EXIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .busy(busy),
    .cyc_stb(cyc_stb), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
    .cmd_valid(cmd_valid), .cmd_op(op_e), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode), .verify_mode(verify_mode),
    .seq_active(seq_active), .seq_bank(seq_bank)
  );

  assign cmd_op = op_e;
endmodule

// File: rtl/sdp_cmd_decoder_chk.sv
module sdp_cmd_decoder_chk #(
  parameter int               AW     = 20,
  parameter int               BANK_W = 2,
  parameter int               CMP_W  = 15,
  parameter logic [CMP_W-1:0] ADDR_A = 15'h5555
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [AW-1:0]     cmd_addr,
  input logic              id_mode,
  input logic              verify_mode,
  input logic              seq_active,
  input logic [BANK_W-1:0] seq_bank
);
  // R1
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!cmd_valid && $stable(seq_active) && $stable(id_mode)
              && $stable(verify_mode)));

  // R8
  id_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !id_mode);

  // R2
  chip_at_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |-> (cmd_addr[CMP_W-1:0] == ADDR_A));

  // R11
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seq_active |=> (!seq_active || $stable(seq_bank)));
endmodule

bind sdp_cmd_decoder sdp_cmd_decoder_chk #(
  .AW(AW), .BANK_W(BANK_W), .CMP_W(CMP_W), .ADDR_A(ADDR_A)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .id_mode(id_mode),
  .verify_mode(verify_mode), .seq_active(seq_active), .seq_bank(seq_bank)
);

// File: tb/tb_sdp_cmd_decoder.sv
`timescale 1ns/1ps
module tb_sdp_cmd_decoder;
  localparam int MINL = 3;

  logic clk = 0, rst = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1, busy = 0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic        cmd_valid, id_mode, verify_mode, seq_active;
  logic [1:0]  cmd_op, seq_bank;
  logic [19:0] cmd_addr;
  logic [15:0] cmd_data;

  always #5 clk = ~clk;

  sdp_cmd_decoder #(.MIN_LOW(MINL)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .busy(busy), .addr(addr), .data(data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .id_mode(id_mode), .verify_mode(verify_mode),
    .seq_active(seq_active), .seq_bank(seq_bank)
  );

  int n_chk = 0, n_bad = 0, n_cmd = 0;
  logic [1:0]  got_op;
  logic [19:0] got_addr;
  logic [15:0] got_data;

  // reference sequence model
  int m_st = 0, exp_n = 0;
  logic [1:0]  m_bank = 0, exp_op = 0;
  logic        m_id = 0, m_vf = 0;
  logic [19:0] exp_addr = 0;
  logic [15:0] exp_data = 0;

  always @(negedge clk) if (!rst && cmd_valid) begin
    n_cmd++; got_op = cmd_op; got_addr = cmd_addr; got_data = cmd_data;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [1:0] op, input logic [19:0] a, input logic [15:0] d);
    exp_n++; exp_op = op; exp_addr = a; exp_data = d;
  endtask

  task automatic model(input logic [19:0] a, input logic [15:0] d);
    logic [1:0]  b  = a[19:18];
    logic [14:0] lo = a[14:0];
    logic [7:0]  c  = d[7:0];
    bit          sb = (b == m_bank);
    int          nx = 0;
    case (m_st)
      0: if (lo == 15'h5555 && c == 8'hAA) begin nx = 1; m_bank = b; end
      1: if (sb && lo == 15'h2AAA && c == 8'h55) nx = 2;
      2: if (sb && lo == 15'h5555) begin
           if (c == 8'hF0) begin m_id = 0; m_vf = 0; end
           else if (!m_id) begin
             if (c == 8'hA0) nx = 3;
             else if (c == 8'h80) nx = 4;
             else if (c == 8'h90) m_id = 1;
             else if (c == 8'h60) m_vf = 1;
           end
         end
      3: if (sb) emit(2'd0, a, d);
      4: if (sb && lo == 15'h5555 && c == 8'hAA) nx = 5;
      5: if (sb && lo == 15'h2AAA && c == 8'h55) nx = 6;
      6: if (sb) begin
           if (lo == 15'h5555 && c == 8'h10) emit(2'd1, a, d);
           else if (c == 8'h50) emit(2'd2, a, d);
           else if (c == 8'h30) emit(2'd3, a, d);
         end
      default: nx = 0;
    endcase
    m_st = nx;
  endtask

  task automatic check_state(input string req);
    chk(req, "cmd count", n_cmd, exp_n);
    if (exp_n > 0) begin
      chk(req, "op", {30'd0, got_op}, {30'd0, exp_op});
      chk(req, "addr", {12'd0, got_addr}, {12'd0, exp_addr});
      chk(req, "data", {16'd0, got_data}, {16'd0, exp_data});
    end
    chk(req, "id_mode", {31'd0, id_mode}, {31'd0, m_id});
    chk(req, "verify_mode", {31'd0, verify_mode}, {31'd0, m_vf});
    chk(req, "seq_active", {31'd0, seq_active}, {31'd0, m_st != 0});
    if (m_st != 0) chk(req, "seq_bank", {30'd0, seq_bank}, {30'd0, m_bank});
  endtask

  // one write cycle; ce_ctl selects which strobe falls last and rises first
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input bit ce_ctl,
                    input int nlow, input bit inh);
    @(negedge clk); addr = a; data = d; oe_n = !inh;
    if (ce_ctl) we_n = 0; else ce_n = 0;
    @(negedge clk);
    if (ce_ctl) ce_n = 0; else we_n = 0;
    repeat (nlow) @(negedge clk);
    if (ce_ctl) ce_n = 1; else we_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    if (nlow >= MINL && !inh && !busy) model(a, d);
    repeat (6) @(negedge clk);
  endtask

  // strobes skewed, address and data moving while strobes are low
  task automatic wr_skew(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk); addr = a ^ 20'h0F0F0; data = ~d; we_n = 0;
    @(negedge clk); addr = a;
    @(negedge clk); ce_n = 0;
    @(negedge clk); addr = a ^ 20'h00AAA;
    repeat (MINL) @(negedge clk);
    data = d;
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1; data = ~d;
    model(a, d);
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [19:0] a);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [19:0] mk(input logic [1:0] b, input logic [14:0] lo);
    return {b, 3'($urandom), lo};
  endfunction

  task automatic unlock(input logic [1:0] b, input logic [7:0] hi);
    wr(mk(b, 15'h5555), {hi, 8'hAA}, 0, MINL, 0);
    wr(mk(b, 15'h2AAA), {~hi, 8'h55}, 0, MINL, 0);
  endtask

  task automatic erase(input logic [1:0] b, input logic [19:0] fa, input logic [7:0] fc);
    unlock(b, 8'h00);
    wr(mk(b, 15'h5555), 16'h0080, 0, MINL, 0);
    unlock(b, 8'h12);
    wr(fa, {8'h77, fc}, 0, MINL, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "cmd_valid", {31'd0, cmd_valid}, 0);
    check_state("R12");

    // R1 program, R3 high byte of command cycles ignored
    unlock(2'd1, 8'hC3);
    wr({2'd1, 3'd0, 15'h5555}, 16'h5AA0, 0, MINL, 0);
    wr({2'd1, 18'h01234}, 16'hBEEF, 1, MINL + 2, 0);
    check_state("R1 R3 program");

    // R4 skewed strobes, moving address and late data
    wr_skew({2'd2, 3'd5, 15'h5555}, 16'h00AA);
    wr({2'd2, 3'd0, 15'h2AAA}, 16'h0055, 1, MINL, 0);
    wr({2'd2, 3'd0, 15'h5555}, 16'h00A0, 0, MINL, 0);
    wr_skew({2'd2, 18'h3ABCD}, 16'hC001);
    check_state("R4 skew");

    // R2 chip, block, sector
    erase(2'd0, {2'd0, 3'd0, 15'h5555}, 8'h10);
    check_state("R2 chip");
    erase(2'd3, {2'd3, 18'h18000}, 8'h50);
    check_state("R2 block");
    erase(2'd1, {2'd1, 18'h00C00}, 8'h30);
    check_state("R2 sector");

    // R5 wrong code aborts; the remainder issues nothing
    wr({2'd0, 3'd0, 15'h5555}, 16'h00AA, 0, MINL, 0);
    wr({2'd0, 3'd0, 15'h2AAA}, 16'h0056, 0, MINL, 0);
    check_state("R5 abort");
    wr({2'd0, 3'd0, 15'h5555}, 16'h00A0, 0, MINL, 0);
    wr({2'd0, 18'h00100}, 16'h1111, 0, MINL, 0);
    check_state("R5 no command after abort");

    // R11 reservation and other-bank abort
    wr({2'd3, 3'd0, 15'h5555}, 16'h00AA, 0, MINL, 0);
    check_state("R11 reserve");
    wr({2'd2, 3'd0, 15'h2AAA}, 16'h0055, 0, MINL, 0);
    check_state("R11 other bank");

    // R6 busy freezes state, sequence resumes afterwards
    unlock(2'd2, 8'h00);
    busy = 1;
    unlock(2'd2, 8'h00);
    wr({2'd2, 3'd0, 15'h5555}, 16'h0090, 0, MINL, 0);
    wr({2'd0, 3'd0, 15'h1234}, 16'h00FF, 1, MINL, 0);
    check_state("R6 busy");
    busy = 0;
    wr({2'd2, 3'd0, 15'h5555}, 16'h00A0, 0, MINL, 0);
    wr({2'd2, 18'h02222}, 16'h4242, 0, MINL, 0);
    check_state("R6 resume");

    // R7 reads between cycles, OE-low write inhibited
    wr({2'd1, 3'd0, 15'h5555}, 16'h00AA, 0, MINL, 0);
    rd({2'd0, 18'h00010});
    wr({2'd1, 3'd0, 15'h2AAA}, 16'h0055, 0, MINL, 0);
    rd({2'd1, 18'h00020});
    wr({2'd1, 3'd0, 15'h5555}, 16'h0012, 0, MINL, 1);
    check_state("R7 inhibit");
    wr({2'd1, 3'd0, 15'h5555}, 16'h00A0, 0, MINL, 0);
    rd({2'd3, 18'h00030});
    wr({2'd1, 18'h00777}, 16'h7777, 0, MINL, 0);
    check_state("R7 reads");

    // R10 glitch below threshold, exact threshold accepted
    wr({2'd0, 3'd0, 15'h5555}, 16'h00AA, 0, MINL - 1, 0);
    check_state("R10 glitch");
    wr({2'd0, 3'd0, 15'h5555}, 16'h00AA, 0, MINL, 0);
    check_state("R10 threshold");
    wr({2'd0, 3'd0, 15'h2AAA}, 16'h0000, 0, MINL, 0);

    // R8 identification mode
    unlock(2'd0, 8'h00);
    wr({2'd0, 3'd0, 15'h5555}, 16'h0090, 0, MINL, 0);
    check_state("R8 enter");
    unlock(2'd0, 8'h00);
    wr({2'd0, 3'd0, 15'h5555}, 16'h00A0, 0, MINL, 0);
    wr({2'd0, 18'h00444}, 16'h4444, 0, MINL, 0);
    erase(2'd0, {2'd0, 3'd0, 15'h5555}, 8'h10);
    check_state("R8 blocked");
    unlock(2'd0, 8'h00);
    wr({2'd0, 3'd0, 15'h5555}, 16'h00F0, 0, MINL, 0);
    check_state("R8 exit");

    // R9 erase-verify mode
    unlock(2'd3, 8'h00);
    wr({2'd3, 3'd0, 15'h5555}, 16'h0060, 0, MINL, 0);
    check_state("R9 enter");
    erase(2'd3, {2'd3, 18'h00400}, 8'h30);
    check_state("R9 erase allowed");
    unlock(2'd3, 8'h00);
    wr({2'd3, 3'd0, 15'h5555}, 16'h00F0, 0, MINL, 0);
    check_state("R9 exit");

    // randomized sequences with corruption, busy and glitches
    for (int it = 0; it < 200; it++) begin
      logic [19:0] sa [6];
      logic [15:0] sd [6];
      int n, kind;
      logic [1:0] b;
      b = 2'($urandom);
      kind = $urandom_range(0, 6);
      sa[0] = mk(b, 15'h5555); sd[0] = {8'($urandom), 8'hAA};
      sa[1] = mk(b, 15'h2AAA); sd[1] = {8'($urandom), 8'h55};
      sa[2] = mk(b, 15'h5555);
      n = 3;
      case (kind)
        0: begin sd[2] = 16'h00A0; sa[3] = {b, 18'($urandom)}; sd[3] = 16'($urandom); n = 4; end
        4: sd[2] = 16'h0090;
        5: sd[2] = 16'h00F0;
        6: sd[2] = 16'h0060;
        default: begin
          sd[2] = 16'h0080;
          sa[3] = mk(b, 15'h5555); sd[3] = 16'h00AA;
          sa[4] = mk(b, 15'h2AAA); sd[4] = 16'h0055;
          sa[5] = (kind == 1) ? mk(b, 15'h5555) : {b, 18'($urandom)};
          sd[5] = {8'($urandom), (kind == 1) ? 8'h10 : (kind == 2) ? 8'h50 : 8'h30};
          n = 6;
        end
      endcase
      if ($urandom_range(0, 5) == 0) begin
        int k = $urandom_range(0, n - 1);
        if ($urandom_range(0, 1) == 0) sd[k][7:0] = sd[k][7:0] ^ 8'h04;
        else sa[k][19:18] = sa[k][19:18] + 2'd1;
      end
      for (int i = 0; i < n; i++) begin
        int nl = ($urandom_range(0, 9) == 0) ? MINL - 1 : MINL + $urandom_range(0, 2);
        busy = ($urandom_range(0, 9) == 0);
        wr(sa[i], sd[i], $urandom_range(0, 1) == 1, nl, 0);
        busy = 0;
      end
      check_state("R5 R6 R10 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule